// File: doc/BRIEF.md
# Scaled Fixed-Point Timestamp Counter

This block keeps a free-running system timestamp for a group of timers. Internally it holds an 88-bit accumulator in 64.24 fixed point. When counting is enabled, every pulse on the `tick` input adds an increment to the accumulator. The increment is either a programmable 8.24 scale value or exactly 1.0. The upper 64 bits of the accumulator form the visible count. That count is driven straight out on `count_o` so that neighbouring timers can compare against it.

Software reaches the block through a simple 32-bit word bus that covers two 4 KB frames, each with its own select:

- **Control frame.** Holds the control bits, the two halves of the count, the scale value, a capability word and a block of identification bytes.
- **Status frame.** A read-only view that offers the two count halves and the same kind of identification bytes.

Read data comes back registered, one cycle after the read strobe, and is flagged by `rvalid`. Writes take effect at the clock edge where they are presented.

Top module: `tstamp_counter`

## Requirements
- R1: After a synchronous reset:
  - the control word reads 0;
  - both count halves read 0 and `count_o` is 0;
  - the scale word (control frame, byte offset 0x10) reads 0x01000000.
- R2: The control word at control offset 0x0 stores bits 4:0: bit 0 run, bit 1 debug-halt, bit 2 scale select, bit 3 mask, bit 4 error-disable. Bits 31:5 read back as zero whatever was written to them.
- R3: While control bit 0 is clear, ticks do not change the count.
- R4: With bit 0 set and bit 2 clear, each tick raises the 64-bit count by exactly 1. A carry out of the low word (offset 0x8) propagates into the high word (offset 0xC).
- R5: With bits 0 and 2 set, each tick adds the scale word to the 88-bit accumulator, and the count is the accumulator's top 64 bits. For example, a scale of 0x00800000 advances the count by 1 every second tick.
- R6: The scale word is read and written at control offsets 0x10 and 0xD0 alike. Offset 0xD4 reads zero and ignores writes. A new scale value applies from the next tick.
- R7: Control offset 0x4 always reads 0. Control offset 0x1C always reads 0x00020001.
- R8: A write to control offset 0x8 (low half) or 0xC (high half) replaces that half of the count and leaves the other half unchanged. The same write clears the 24 fraction bits.
- R9: When a count write and a tick fall in the same cycle, the written value is what remains and the tick is dropped.
- R10: The status frame returns the count low half at offset 0x0 and the high half at offset 0x4. Writes to the status frame change nothing.
- R11: Both frames have identification bytes at word offsets 0xFD0 through 0xFFC, in this order:

  | Offset | 0xFD0 | 0xFD4 | 0xFD8 | 0xFDC | 0xFE0 | 0xFE4 | 0xFE8 | 0xFEC | 0xFF0 | 0xFF4 | 0xFF8 | 0xFFC |
  |---|---|---|---|---|---|---|---|---|---|---|---|---|
  | Value | 0x04 | 0 | 0 | 0 | see below | 0xB0 | 0x0B | 0x00 | 0x0D | 0xF0 | 0x05 | 0xB1 |

  The byte at 0xFE0 is 0xBA in the control frame and 0xBB in the status frame.
- R12: Reads of unmapped offsets return 0. Writes to read-only or unmapped offsets change no state.
- R13: `rvalid` is high exactly in the cycle after an accepted read, and `count_o` always equals the 64-bit count seen over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count pulse, one increment per high cycle |
| ctl_sel | input | 1 | Selects the control frame |
| sts_sel | input | 1 | Selects the status frame |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset within the frame (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after the read |
| count_o | output | 64 | Visible 64-bit timestamp |

## Verification
A wrong accumulator or a wrong step selection shows up on `count_o` on the edge after the offending tick. The exception is a fraction error under a scale below 1.0: that error only reaches the integer part on a later tick, so the bench walks through half-step scales tick by tick. Control or scale register corruption appears only when the register is read back, or through a changed step size on the next tick. Decode mistakes show as a wrong `rdata` word one cycle after the read strobe.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int BUS_W   = 32;
  localparam int WIDX_W  = 10;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_CTRL      = 10'h000;
  localparam logic [WIDX_W-1:0] W_STAT      = 10'h001;
  localparam logic [WIDX_W-1:0] W_CNT_LO    = 10'h002;
  localparam logic [WIDX_W-1:0] W_CNT_HI    = 10'h003;
  localparam logic [WIDX_W-1:0] W_SCALE     = 10'h004;
  localparam logic [WIDX_W-1:0] W_CAPS      = 10'h007;
  localparam logic [WIDX_W-1:0] W_SCALE_ALT = 10'h034;
  localparam logic [WIDX_W-1:0] W_SCALE_2ND = 10'h035;
  localparam logic [WIDX_W-1:0] W_ID_FIRST  = 10'h3F4;
  localparam logic [WIDX_W-1:0] W_STS_LO    = 10'h000;
  localparam logic [WIDX_W-1:0] W_STS_HI    = 10'h001;

  localparam logic [BUS_W-1:0] CAPS_VALUE   = 32'h0002_0001;
  localparam logic [BUS_W-1:0] SCALE_RESET  = 32'h0100_0000;

  typedef struct packed {
    logic err_dis;
    logic irq_mask;
    logic scale_on;
    logic dbg_halt;
    logic run;
  } ctrl_t;

  // identification byte for slot 0..11 of the ID block
  function automatic logic [7:0] id_byte(input logic [3:0] slot, input logic status_frame);
    case (slot)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = status_frame ? 8'hBB : 8'hBA;
      4'd5:    id_byte = 8'hB0;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tsc_accum.sv
module tsc_accum #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              scale_on,
  input  logic [DATA_W-1:0] scale,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [2*DATA_W-1:0] count
);
  localparam int INT_W = 2 * DATA_W;
  localparam int ACC_W = INT_W + FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;

  always_comb begin
    if (scale_on) step = ACC_W'(scale);
    else          step = ACC_W'(1) << FRAC_W;
  end

  // count writes win over a coincident tick (R9); they also drop the fraction (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (wr_lo || wr_hi) begin
      acc[FRAC_W-1:0] <= '0;
      if (wr_lo) acc[FRAC_W +: DATA_W]          <= wdata;
      if (wr_hi) acc[FRAC_W + DATA_W +: DATA_W] <= wdata;
    end else if (tick && run) begin
      acc <= acc + step;
    end
  end

  assign count = acc[ACC_W-1 -: INT_W];
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_ctl,
  input  logic                sel_sts,
  input  logic                wr,
  input  logic                rd,
  input  logic [WIDX_W-1:0]   widx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] count,
  output ctrl_t               ctrl,
  output logic [DATA_W-1:0]   scale,
  output logic                wr_lo,
  output logic                wr_hi,
  output logic [DATA_W-1:0]   rdata,
  output logic                rvalid
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic              ctl_wr;
  logic              id_hit;
  logic [3:0]        id_slot;
  logic [DATA_W-1:0] rd_mux;

  assign ctl_wr  = sel_ctl && wr;
  assign wr_lo   = ctl_wr && (widx == W_CNT_LO);
  assign wr_hi   = ctl_wr && (widx == W_CNT_HI);
  assign id_hit  = (widx >= W_ID_FIRST);
  assign id_slot = 4'(widx - W_ID_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      scale <= DATA_W'(SCALE_RESET);
    end else if (ctl_wr) begin
      if (widx == W_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (widx == W_SCALE || widx == W_SCALE_ALT) scale <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctl) begin
      if (id_hit) rd_mux = DATA_W'(id_byte(id_slot, 1'b0));
      else begin
        case (widx)
          W_CTRL:      rd_mux = DATA_W'(ctrl);
          W_CNT_LO:    rd_mux = count[DATA_W-1:0];
          W_CNT_HI:    rd_mux = count[2*DATA_W-1:DATA_W];
          W_SCALE,
          W_SCALE_ALT: rd_mux = scale;
          W_CAPS:      rd_mux = DATA_W'(CAPS_VALUE);
          default:     rd_mux = '0;
        endcase
      end
    end else if (sel_sts) begin
      if (id_hit) rd_mux = DATA_W'(id_byte(id_slot, 1'b1));
      else begin
        case (widx)
          W_STS_LO: rd_mux = count[DATA_W-1:0];
          W_STS_HI: rd_mux = count[2*DATA_W-1:DATA_W];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd && (sel_ctl || sel_sts);
      if (rd && (sel_ctl || sel_sts)) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tsc_pkg::*;
#(
  parameter int FRAC_W = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        ctl_sel,
  input  logic        sts_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic [63:0] count_o
);
  ctrl_t       ctrl;
  logic [31:0] scale;
  logic        wr_lo;
  logic        wr_hi;
  logic        ctl_en;
  logic        ctl_scen;

  assign ctl_en   = ctrl.run;
  assign ctl_scen = ctrl.scale_on;

  tsc_regs #(.DATA_W(BUS_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel_ctl (ctl_sel),
    .sel_sts (sts_sel),
    .wr      (wr_en),
    .rd      (rd_en),
    .widx    (addr[11:2]),
    .wdata   (wdata),
    .count   (count_o),
    .ctrl    (ctrl),
    .scale   (scale),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );

  tsc_accum #(.DATA_W(BUS_W), .FRAC_W(FRAC_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (ctl_en),
    .scale_on (ctl_scen),
    .scale    (scale),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (wdata),
    .count    (count_o)
  );
endmodule

// File: rtl/tstamp_counter_chk.sv
module tstamp_counter_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        ctl_sel,
  input logic        sts_sel,
  input logic        wr_en,
  input logic        rd_en,
  input logic [11:0] addr,
  input logic [31:0] wdata,
  input logic        rvalid,
  input logic [63:0] count_o,
  input logic        ctl_en,
  input logic        ctl_scen
);
  logic cnt_wr_lo, cnt_wr_hi, cnt_wr;
  assign cnt_wr_lo = ctl_sel && wr_en && (addr[11:2] == 10'h002);
  assign cnt_wr_hi = ctl_sel && wr_en && (addr[11:2] == 10'h003);
  assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !cnt_wr) |=> $stable(count_o));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_en && !ctl_scen && tick && !cnt_wr) |=> (count_o == $past(count_o) + 64'd1));

  assert_low_write_keeps_high_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_lo |=> (count_o[63:32] == $past(count_o[63:32])));

  assert_write_beats_tick_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_lo |=> (count_o[31:0] == $past(wdata)));

  assert_status_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (sts_sel && !ctl_sel && wr_en && !(ctl_en && tick)) |=> $stable(count_o));

  assert_rvalid_after_read_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (ctl_sel || sts_sel)) |=> rvalid);

  assert_no_spurious_rvalid_R13: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (ctl_sel || sts_sel)) |=> !rvalid);
endmodule

bind tstamp_counter tstamp_counter_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .ctl_sel  (ctl_sel),
  .sts_sel  (sts_sel),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rvalid   (rvalid),
  .count_o  (count_o),
  .ctl_en   (ctl_en),
  .ctl_scen (ctl_scen)
);

// File: tb/test_tstamp_counter.sv
module test_tstamp_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ctl_sel = 1'b0;
  logic        sts_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [63:0] count_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tstamp_counter i_tstamp_counter (
    .clk(clk), .rst(rst), .tick(tick), .ctl_sel(ctl_sel), .sts_sel(sts_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .count_o(count_o)
  );

  // monitor: compare returned read data against the scoreboard
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13: read data %h with no read pending (expected none)", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input bit stat, input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    ctl_sel = !stat; sts_sel = stat; rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    ctl_sel = 1'b0; sts_sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input bit stat, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ctl_sel = !stat; sts_sel = stat; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ctl_sel = 1'b0; sts_sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_count(input logic [63:0] e, input string t);
    @(negedge clk);
    n_checks++;
    if (count_o !== e) begin
      n_fail++;
      $display("FAIL %s: count_o %h expected %h", t, count_o, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_count(64'd0, "R1");
    rd(0, 12'h000, 32'h0, "R1");
    rd(0, 12'h010, 32'h0100_0000, "R1");
    rd(0, 12'h008, 32'h0, "R1");
    rd(0, 12'h00C, 32'h0, "R1");

    // R7 fixed words
    rd(0, 12'h004, 32'h0, "R7");
    rd(0, 12'h01C, 32'h0002_0001, "R7");

    // R2 control fields, run bit clear
    wr(0, 12'h000, 32'hFFFF_FFFE);
    rd(0, 12'h000, 32'h0000_001E, "R2");

    // R3 disabled: ticks ignored
    ticks(5);
    rd(0, 12'h008, 32'h0, "R3");
    chk_count(64'd0, "R3");

    // R4 unit step
    wr(0, 12'h000, 32'h1);
    ticks(10);
    rd(0, 12'h008, 32'd10, "R4");
    chk_count(64'd10, "R13");

    // R6 scale alias and dead second scale
    wr(0, 12'h0D0, 32'h0080_0000);
    rd(0, 12'h010, 32'h0080_0000, "R6");
    wr(0, 12'h0D4, 32'h0000_FFFF);
    rd(0, 12'h0D4, 32'h0, "R6");
    rd(0, 12'h0D0, 32'h0080_0000, "R6");

    // R5 half-step scaling
    wr(0, 12'h000, 32'h5);
    ticks(4);
    rd(0, 12'h008, 32'd12, "R5");
    ticks(1);
    rd(0, 12'h008, 32'd12, "R5");
    ticks(1);
    rd(0, 12'h008, 32'd13, "R5");

    // R8 write clears the fraction
    ticks(1);                       // fraction now one half
    wr(0, 12'h008, 32'h0000_0100);
    ticks(1);
    rd(0, 12'h008, 32'h0000_0100, "R8");
    ticks(1);
    rd(0, 12'h008, 32'h0000_0101, "R8");
    wr(0, 12'h00C, 32'hABCD_0000);
    rd(0, 12'h00C, 32'hABCD_0000, "R8");
    rd(0, 12'h008, 32'h0000_0101, "R8");

    // R9 write and tick in the same cycle
    wr(0, 12'h000, 32'h1);
    @(negedge clk);
    ctl_sel = 1'b1; wr_en = 1'b1; addr = 12'h008; wdata = 32'h55; tick = 1'b1;
    @(negedge clk);
    ctl_sel = 1'b0; wr_en = 1'b0; tick = 1'b0;
    rd(0, 12'h008, 32'h55, "R9");

    // R4 carry into high half
    wr(0, 12'h008, 32'hFFFF_FFFF);
    ticks(1);
    rd(0, 12'h008, 32'h0, "R4");
    rd(0, 12'h00C, 32'hABCD_0001, "R4");

    // R10 status frame
    rd(1, 12'h000, 32'h0, "R10");
    rd(1, 12'h004, 32'hABCD_0001, "R10");
    wr(1, 12'h000, 32'h1234);
    wr(1, 12'h004, 32'h1);
    rd(0, 12'h00C, 32'hABCD_0001, "R10");
    rd(0, 12'h008, 32'h0, "R10");

    // R11 identification bytes
    rd(0, 12'hFE0, 32'hBA, "R11");
    rd(1, 12'hFE0, 32'hBB, "R11");
    rd(0, 12'hFD0, 32'h04, "R11");
    rd(1, 12'hFFC, 32'hB1, "R11");
    rd(0, 12'hFF4, 32'hF0, "R11");
    rd(0, 12'hFE8, 32'h0B, "R11");
    rd(1, 12'hFD4, 32'h00, "R11");

    // R12 unmapped and read-only
    rd(0, 12'h020, 32'h0, "R12");
    rd(1, 12'h008, 32'h0, "R12");
    wr(0, 12'h01C, 32'hFFFF);
    rd(0, 12'h01C, 32'h0002_0001, "R12");
    wr(0, 12'h024, 32'h5);
    rd(0, 12'h000, 32'h1, "R12");
    wr(0, 12'h004, 32'h7);
    rd(0, 12'h004, 32'h0, "R12");

    chk_count(64'hABCD_0001_0000_0000, "R13");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R13: %0d reads unanswered (expected 0)", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung (expected completion)");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule